// File: doc/BRIEF.md
# Doubling-Stride Maximum Finder

This block finds the largest of N unsigned keys. The keys arrive together on one wide input bus, and a single-cycle start strobe captures them. The block holds one register per key position. Each position keeps a running maximum. In every round, all positions update on the same clock edge: each one compares its own value with the value held a fixed stride further up the array. The stride is 1 in the first round and doubles after each round. After lg N rounds the lowest position holds the maximum of all keys.

The block needs no comparator tree and no write arbitration, because each position writes only its own register. The lowest position drives the result output at all times. A one-cycle done flag marks the cycle in which that result is final. N must be a power of two and at least 2.

Top module: `pmax_unit`

## Requirements
- R1: While reset is held, and in the first cycle after reset, done_o is 0 and max_o is 0.
- R2: A start strobe sampled while no rounds are running loads key k (keys_i bits [k*KEY_W +: KEY_W]) into position k. In the next cycle max_o equals key 0.
- R3: In each round, every position k takes the unsigned larger of its own value and the value at position k+stride. Positions past N-1 read as zero. After round t, max_o equals the largest of keys 0 .. 2^t-1.
- R4: The stride is 1 in the first round and doubles in each later round. Exactly lg N rounds run after every accepted start.
- R5: Suppose a start is accepted on clock edge E. Then done_o is high only in the cycle after edge E+lg N, and only for that one cycle. In that cycle max_o equals the unsigned maximum of all N keys.
- R6: A start strobe sampled while rounds are running has no effect. The running computation's result and the timing of its done_o do not change.
- R7: While no start is accepted and no round runs, max_o holds its last value.
- R8: A start sampled in the done cycle, or in any other idle cycle, is accepted. If start is held high, a new computation begins on the edge right after each done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe; captures the keys when idle |
| keys_i | input | N_KEYS*KEY_W | N packed unsigned keys; key k at bits [k*KEY_W +: KEY_W] |
| max_o | output | KEY_W | Running maximum held at the lowest position |
| done_o | output | 1 | One-cycle flag: max_o is the final maximum |

## Verification
The keys are tried in several arrangements:
- Ascending keys place the maximum at the top position, so it has to travel the full distance across every round. A wrong stride or a missing round shows up here.
- Descending keys place the maximum at position 0, which shows whether a comparison ever lets a smaller key win.
- Equal keys, all-zero keys and all-ones keys exercise ties and the extremes of the unsigned range.
- A lone maximum in the middle of the array tests one specific stride path.

A reference model compares the prefix maximum after every round. This separates a wrong round order from an error that only appears in the final result. A start pulse injected during the rounds, and a start held high over two computations, separate an ignored start from a restart.

// File: rtl/pmax_pkg.sv
`timescale 1ns/1ps
package pmax_pkg;
  // Distance to the neighbour read in a given round (0-based round).
  function automatic int stride_for(input int rnd);
    return 1 << rnd;
  endfunction

  // Index of the neighbour position k reads in round rnd.
  function automatic int nbr_index(input int k, input int rnd);
    return k + stride_for(rnd);
  endfunction

  // Number of rounds needed for n positions.
  function automatic int rounds_for(input int n);
    return $clog2(n);
  endfunction
endpackage

// File: rtl/pmax_cell.sv
`timescale 1ns/1ps
module pmax_cell #(
  parameter int KEY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             step_i,
  input  logic [KEY_W-1:0] key_i,
  input  logic [KEY_W-1:0] nbr_i,
  output logic [KEY_W-1:0] val_o
);
  function automatic logic [KEY_W-1:0] larger(input logic [KEY_W-1:0] a,
                                              input logic [KEY_W-1:0] b);
    return (b > a) ? b : a;
  endfunction

  logic [KEY_W-1:0] val_q;
  logic [KEY_W-1:0] round_next;

  assign round_next = larger(val_q, nbr_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      val_q <= '0;
    end else if (load_i) begin
      val_q <= key_i;
    end else if (step_i) begin
      val_q <= round_next;
    end
  end

  assign val_o = val_q;

  AST_CELL_NONDECREASE: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i) |=> (val_o >= $past(val_o))); // R3
  AST_CELL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (val_o == $past(key_i))); // R2
endmodule

// File: rtl/pmax_seq.sv
`timescale 1ns/1ps
module pmax_seq #(
  parameter int LG_N  = 3,
  parameter int RND_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  output logic             load_o,
  output logic             step_o,
  output logic [RND_W-1:0] round_o,
  output logic             done_o
);
  localparam logic [RND_W-1:0] LAST_RND = RND_W'(LG_N - 1);

  logic             running_q;
  logic [RND_W-1:0] round_q;
  logic             done_q;
  logic             last_round;

  assign load_o     = start_i & ~running_q;
  assign step_o     = running_q;
  assign last_round = running_q && (round_q == LAST_RND);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running_q <= 1'b0;
      round_q   <= '0;
      done_q    <= 1'b0;
    end else begin
      done_q <= last_round;
      if (load_o) begin
        running_q <= 1'b1;
        round_q   <= '0;
      end else if (running_q) begin
        round_q <= round_q + 1'b1;
        if (last_round) running_q <= 1'b0;
      end
    end
  end

  assign round_o = round_q;
  assign done_o  = done_q;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R5
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !running_q); // R5
  AST_ROUND_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    round_q <= RND_W'(LG_N)); // R4
  AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
    (running_q && start_i && !last_round) |=>
      (running_q && round_q == $past(round_q) + 1'b1)); // R6
endmodule

// File: rtl/pmax_unit.sv
`timescale 1ns/1ps
module pmax_unit #(
  parameter int KEY_W  = 8,
  parameter int N_KEYS = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_i,
  input  logic [N_KEYS*KEY_W-1:0] keys_i,
  output logic [KEY_W-1:0]        max_o,
  output logic                    done_o
);
  localparam int LG_N  = pmax_pkg::rounds_for(N_KEYS);
  localparam int RND_W = $clog2(LG_N + 1);

  logic             load_w;
  logic             step_w;
  logic [RND_W-1:0] round_w;
  logic             done_w;

  logic [KEY_W-1:0] cell_val [N_KEYS];
  logic [KEY_W-1:0] cell_nbr [N_KEYS];
  logic [KEY_W-1:0] cand     [N_KEYS][LG_N];

  pmax_seq #(.LG_N(LG_N), .RND_W(RND_W)) seq_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .load_o(load_w), .step_o(step_w), .round_o(round_w), .done_o(done_w)
  );

  for (genvar g = 0; g < N_KEYS; g++) begin : g_cell
    for (genvar r = 0; r < LG_N; r++) begin : g_rnd
      localparam int IDX = pmax_pkg::nbr_index(g, r);
      if (IDX < N_KEYS) begin : g_in
        assign cand[g][r] = cell_val[IDX];
      end else begin : g_pad
        assign cand[g][r] = '0;
      end
    end

    always_comb begin
      cell_nbr[g] = '0;
      for (int r = 0; r < LG_N; r++) begin
        if (round_w == RND_W'(r)) cell_nbr[g] = cand[g][r];
      end
    end

    pmax_cell #(.KEY_W(KEY_W)) cell_i (
      .clk(clk), .rst_n(rst_n), .load_i(load_w), .step_i(step_w),
      .key_i(keys_i[g*KEY_W +: KEY_W]), .nbr_i(cell_nbr[g]),
      .val_o(cell_val[g])
    );
  end

  assign max_o  = cell_val[0];
  assign done_o = done_w;

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_w && !step_w) |=> $stable(max_o)); // R7
  AST_DONE_COVERS_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (max_o >= cell_val[N_KEYS-1])); // R3
endmodule

// File: tb/pmax_unit_tb_top.sv
`timescale 1ns/1ps
module pmax_unit_tb_top;
  localparam int KW = 8;
  localparam int NK = 8;
  localparam int LG = 3;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start_i = 1'b0;
  logic [NK*KW-1:0] keys_i = '0;
  logic [KW-1:0]   max_o;
  logic            done_o;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  pmax_unit #(.KEY_W(KW), .N_KEYS(NK)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .keys_i(keys_i),
    .max_o(max_o), .done_o(done_o)
  );

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  // Behavioural reference: prefix maximum after each round.
  int m_keys[NK];
  int m_prefix = 0;
  bit m_busy = 0;
  int m_round = 0;
  bit m_done = 0;

  function automatic int prefix_max(input int cnt);
    int r = 0;
    for (int k = 0; k < cnt && k < NK; k++) if (m_keys[k] > r) r = m_keys[k];
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_round = 0; m_done = 0; m_prefix = 0;
    end else begin
      m_done = 0;
      if (start_i && !m_busy) begin
        for (int k = 0; k < NK; k++) m_keys[k] = int'(keys_i[k*KW +: KW]);
        m_busy = 1; m_round = 0; m_prefix = m_keys[0];
      end else if (m_busy) begin
        m_round++;
        m_prefix = prefix_max(1 << m_round);
        if (m_round == LG) begin m_busy = 0; m_done = 1; end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      check(m_busy ? "R3 prefix max" : "R7 held max", int'(max_o), m_prefix);
      check("R5 done timing", int'(done_o), int'(m_done));
    end
  end

  function automatic int true_max(input int v[NK]);
    int r = 0;
    for (int k = 0; k < NK; k++) if (v[k] > r) r = v[k];
    return r;
  endfunction

  task automatic put_keys(input int v[NK]);
    for (int k = 0; k < NK; k++) keys_i[k*KW +: KW] = KW'(v[k]);
  endtask

  task automatic run_case(input int v[NK]);
    @(negedge clk); put_keys(v); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    check("R2 key0 after load", int'(max_o), v[0]);
    repeat (LG - 1) begin
      @(negedge clk);
      check("R4 no early done", int'(done_o), 0);
    end
    @(negedge clk);
    check("R4 done after lgN rounds", int'(done_o), 1);
    check("R5 final max", int'(max_o), true_max(v));
    @(negedge clk);
    check("R5 done one cycle", int'(done_o), 0);
    check("R7 result held", int'(max_o), true_max(v));
  endtask

  bit finished = 0;

  initial begin
    int a[NK];
    int b[NK];
    repeat (3) @(negedge clk);
    check("R1 reset done", int'(done_o), 0);
    check("R1 reset max", int'(max_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset done", int'(done_o), 0);
    check("R1 after reset max", int'(max_o), 0);

    for (int k = 0; k < NK; k++) a[k] = 10 + k * 20;       run_case(a);
    for (int k = 0; k < NK; k++) a[k] = 200 - k * 20;      run_case(a);
    for (int k = 0; k < NK; k++) a[k] = 77;                run_case(a);
    for (int k = 0; k < NK; k++) a[k] = 0;                 run_case(a);
    for (int k = 0; k < NK; k++) a[k] = 255;               run_case(a);
    for (int k = 0; k < NK; k++) a[k] = (k * 37) % 50;
    a[5] = 250;                                            run_case(a);
    for (int k = 0; k < NK; k++) a[k] = 0;
    a[NK-1] = 1;                                           run_case(a);
    for (int k = 0; k < NK; k++) a[k] = (k % 2 == 0) ? 128 : 127;
    run_case(a);

    // R6: start during rounds is ignored.
    for (int k = 0; k < NK; k++) begin a[k] = 5 + k; b[k] = 240 - k; end
    @(negedge clk); put_keys(a); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    @(negedge clk); put_keys(b); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    @(negedge clk);
    check("R6 done unchanged", int'(done_o), 1);
    check("R6 result of first run", int'(max_o), true_max(a));
    repeat (3) @(negedge clk);
    check("R6 no hidden restart", int'(done_o), 0);
    check("R7 max still held", int'(max_o), true_max(a));

    // R8: start held high restarts right after done.
    for (int k = 0; k < NK; k++) a[k] = 3 * k + 1;
    @(negedge clk); put_keys(a); start_i = 1'b1;
    repeat (LG + 1) @(negedge clk);
    check("R8 first done", int'(done_o), 1);
    for (int k = 0; k < NK; k++) b[k] = 90 - k;
    put_keys(b);
    @(negedge clk);
    check("R8 reload in done cycle", int'(max_o), b[0]);
    repeat (LG) @(negedge clk);
    check("R8 second done", int'(done_o), 1);
    check("R8 second max", int'(max_o), true_max(b));
    start_i = 1'b0;
    repeat (LG + 3) @(negedge clk);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 20000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule